// File: doc/BRIEF.md
# Rewindable Nine-Bit Queue with Half-Full Indication

This block is a single-clock first-in, first-out queue of nine-bit words (a byte plus one parity or framing bit) with a parameterised power-of-two depth. One-cycle write and read enables move words in and out. Empty, full and half-full status outputs track the number of words held. Reads are registered: a word that is read appears on the data output one clock later, and a valid strobe marks it.

A rewind input moves the read position back to the first storage location and leaves the write position unchanged. Everything written since reset can then be read again, as long as fewer than a depth's worth of words has been written since reset. A read that is requested together with a write on an empty queue takes the incoming word directly. A write that is requested together with a read on a full queue is completed in the slot that the read frees.

Top module: `rtf_fifo`

## Requirements
- R1: While synchronous reset `rst` is high, both positions return to location zero. On the cycle after a reset edge, `empty` is 1 and `full`, `half_full` and `rd_valid` are 0.
- R2: Words are read in the order they were written. A read accepted at a clock edge drives that word on `rd_data`, with `rd_valid` high, from that edge until the next edge.
- R3: `full` is 1 exactly when the number of accepted writes since reset exceeds the number of accepted reads by DEPTH.
- R4: A write while `full` is 1 and `rd_en` is 0 is ignored. The stored contents and all flags stay unchanged.
- R5: A read while `empty` is 1 and `wr_en` is 0 is ignored. `rd_valid` stays 0 and the read position does not move.
- R6: `half_full` goes to 1 on the write that takes occupancy from DEPTH/2 to DEPTH/2+1. It goes to 0 only on the read that brings occupancy back to exactly DEPTH/2.
- R7: With `rewind` high and both enables low, the read position goes to location zero and the write position is kept. Occupancy and all three flags are recomputed from the new difference, so the words from location zero onward are read again in order.
- R8: `rewind` has no effect in a cycle where `wr_en` or `rd_en` is high. That cycle acts as an ordinary read and/or write.
- R9: With `empty` at 1, `rd_en` and `wr_en` together deliver `wr_data` on `rd_data` one edge later with `rd_valid` high, and `empty` stays 1.
- R10: With `full` at 1, `rd_en` and `wr_en` together read the oldest word and store the new word. `full` stays 1.
- R11: A read together with a write on a queue that is neither empty nor full leaves occupancy and flags unchanged and keeps the word order.
- R12: `rd_valid` is 1 only in the cycle after an accepted read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Write request for this cycle |
| wr_data | input | 9 | Word to store |
| rd_en | input | 1 | Read request for this cycle |
| rewind | input | 1 | Move read position back to location zero |
| rd_data | output | 9 | Registered read word |
| rd_valid | output | 1 | `rd_data` holds a word read at the last edge |
| empty | output | 1 | Occupancy is zero |
| full | output | 1 | Occupancy equals DEPTH |
| half_full | output | 1 | Occupancy is above DEPTH/2 |

## Verification
Every result is due one edge after the request that causes it. Flags, `rd_valid` and `rd_data` are registered, or decoded from registered occupancy, so a request presented before edge N shows its effect between edges N and N+1. The driver applies each request at a falling edge and compares the flags and `rd_valid` with its reference model shortly after the following rising edge. The monitor pops expected words from the scoreboard queue at the next falling edge, when `rd_valid` is high, so both comparisons fall inside the one cycle in which the result is defined.

// File: rtl/rtf_pkg.sv
package rtf_pkg;

    localparam int WORD_W = 9;

    typedef logic [WORD_W-1:0] word_t;

    // accepted actions for one cycle, decided by the controller
    typedef struct packed {
        logic put;      // a write lands in storage
        logic take;     // a read is performed
        logic bypass;   // the read takes the incoming word directly
        logic rewind;   // read position goes back to zero
    } action_t;

    function automatic logic above_half(input int unsigned occ, input int unsigned depth);
        return occ > (depth / 2);
    endfunction

endpackage

// File: rtl/rtf_ctrl.sv
module rtf_ctrl
    import rtf_pkg::*;
#(
    parameter int DEPTH  = 16,
    parameter int ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic              rewind,
    output action_t           act,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              empty,
    output logic              full,
    output logic              half_full
);

    localparam int CNT_W = ADDR_W + 1;
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);
    localparam logic [CNT_W-1:0] HALF_CNT = CNT_W'(DEPTH / 2);

    logic [ADDR_W-1:0] wp_q, rp_q;
    logic [CNT_W-1:0]  occ_q;
    logic              hf_q;

    assign empty     = (occ_q == '0);
    assign full      = (occ_q == FULL_CNT);
    assign half_full = hf_q;
    assign wr_addr   = wp_q;
    assign rd_addr   = rp_q;

    always_comb begin
        act.put    = wr_en && (!full || rd_en);
        act.take   = rd_en && (!empty || wr_en);
        act.bypass = rd_en && wr_en && empty;
        act.rewind = rewind && !wr_en && !rd_en;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wp_q  <= '0;
            rp_q  <= '0;
            occ_q <= '0;
            hf_q  <= 1'b0;
        end else if (act.rewind) begin
            rp_q  <= '0;
            occ_q <= {1'b0, wp_q};
            hf_q  <= above_half(int'(wp_q), DEPTH);
        end else begin
            if (act.put)  wp_q <= wp_q + 1'b1;
            if (act.take) rp_q <= rp_q + 1'b1;
            unique case ({act.put, act.take})
                2'b10: begin
                    occ_q <= occ_q + 1'b1;
                    if (occ_q == HALF_CNT) hf_q <= 1'b1;
                end
                2'b01: begin
                    occ_q <= occ_q - 1'b1;
                    if (occ_q == HALF_CNT + 1'b1) hf_q <= 1'b0;
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/rtf_store.sv
module rtf_store
    import rtf_pkg::*;
#(
    parameter int DEPTH  = 16,
    parameter int ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  action_t           act,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [ADDR_W-1:0] rd_addr,
    input  word_t             wr_data,
    output word_t             rd_data,
    output logic              rd_valid
);

    word_t cells [DEPTH];
    word_t out_q;
    logic  vld_q;

    always_ff @(posedge clk) begin
        if (act.put) cells[wr_addr] <= wr_data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_q <= '0;
            vld_q <= 1'b0;
        end else begin
            vld_q <= act.take;
            if (act.take) out_q <= act.bypass ? wr_data : cells[rd_addr];
        end
    end

    assign rd_data  = out_q;
    assign rd_valid = vld_q;

endmodule

// File: rtl/rtf_fifo.sv
module rtf_fifo
    import rtf_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              rd_en,
    input  logic              rewind,
    output logic [WORD_W-1:0] rd_data,
    output logic              rd_valid,
    output logic              empty,
    output logic              full,
    output logic              half_full
);

    localparam int ADDR_W = $clog2(DEPTH);

    action_t           act;
    logic [ADDR_W-1:0] wa, ra;

    rtf_ctrl #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_ctrl (
        .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .rewind(rewind),
        .act(act), .wr_addr(wa), .rd_addr(ra),
        .empty(empty), .full(full), .half_full(half_full)
    );

    rtf_store #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_store (
        .clk(clk), .rst(rst), .act(act), .wr_addr(wa), .rd_addr(ra),
        .wr_data(wr_data), .rd_data(rd_data), .rd_valid(rd_valid)
    );

endmodule

// File: rtl/rtf_chk.sv
module rtf_chk
    import rtf_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              wr_en,
    input logic [WORD_W-1:0] wr_data,
    input logic              rd_en,
    input logic              rewind,
    input logic [WORD_W-1:0] rd_data,
    input logic              rd_valid,
    input logic              empty,
    input logic              full,
    input logic              half_full
);

    // R1
    reset_state_chk: assert property (@(posedge clk)
        rst |=> (empty && !full && !half_full && !rd_valid));

    // R4
    full_write_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        (full && wr_en && !rd_en) |=> (full && !rd_valid));

    // R5
    empty_read_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        (empty && rd_en && !wr_en) |=> (empty && !rd_valid));

    // R6
    hf_clear_on_read_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(half_full) |-> ($past(rd_en) && !$past(wr_en)));

    // R6
    hf_set_on_write_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(half_full) |-> (($past(wr_en) && !$past(rd_en)) || $past(rewind)));

    // R9
    bypass_chk: assert property (@(posedge clk) disable iff (rst)
        (empty && rd_en && wr_en) |=> (rd_valid && empty && rd_data == $past(wr_data)));

    // R10
    full_swap_chk: assert property (@(posedge clk) disable iff (rst)
        (full && rd_en && wr_en) |=> (full && rd_valid));

    // R12
    valid_needs_read_chk: assert property (@(posedge clk) disable iff (rst)
        !rd_en |=> !rd_valid);

    // R3
    flags_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
        !(empty && full) && !(empty && half_full));

endmodule

bind rtf_fifo rtf_chk #(.DEPTH(DEPTH)) u_rtf_chk (.*);

// File: tb/test_rtf_fifo.sv
module test_rtf_fifo;
    import rtf_pkg::*;

    localparam int DEPTH = 16;
    localparam int HALF  = DEPTH / 2;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic wr_en = 1'b0, rd_en = 1'b0, rewind = 1'b0;
    word_t wr_data = '0;
    word_t rd_data;
    logic rd_valid, empty, full, half_full;

    int n_chk = 0, n_fail = 0;

    // reference model
    word_t m_mem [DEPTH];
    int m_wp = 0, m_rp = 0, m_cnt = 0;
    word_t exp_q [$];

    always #10 clk = ~clk;

    rtf_fifo #(.DEPTH(DEPTH)) i_rtf_fifo (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en),
        .rewind(rewind), .rd_data(rd_data), .rd_valid(rd_valid),
        .empty(empty), .full(full), .half_full(half_full)
    );

    task automatic check(input string tag, input int act, input int expv);
        n_chk++;
        if (act != expv) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, expv);
        end
    endtask

    // one cycle of stimulus; model updated, flags checked after the edge
    task automatic op(input logic w, input word_t d, input logic r, input logic rw, input string tag);
        logic do_w, do_r;
        @(negedge clk);
        wr_en = w; wr_data = d; rd_en = r; rewind = rw;
        do_w = w && (m_cnt < DEPTH || r);
        do_r = r && (m_cnt > 0 || w);
        @(posedge clk);
        #2;
        if (rw && !w && !r) begin
            m_rp = 0;
            m_cnt = m_wp;
        end else begin
            if (do_r) begin
                exp_q.push_back((m_cnt == 0) ? d : m_mem[m_rp]);
                m_rp = (m_rp + 1) % DEPTH;
            end
            if (do_w) begin
                m_mem[m_wp] = d;
                m_wp = (m_wp + 1) % DEPTH;
            end
            m_cnt = m_cnt + (do_w ? 1 : 0) - (do_r ? 1 : 0);
        end
        check({tag, " empty"}, int'(empty), int'(m_cnt == 0));
        check({tag, " full"}, int'(full), int'(m_cnt == DEPTH));
        check({tag, " half_full"}, int'(half_full), int'(m_cnt > HALF));
        check({tag, " rd_valid (R12)"}, int'(rd_valid), int'(do_r));
        wr_en = 1'b0; rd_en = 1'b0; rewind = 1'b0;
    endtask

    // monitor: pop expected words when the design presents a read
    always @(negedge clk) begin
        if (!rst && rd_valid) begin
            if (exp_q.size() == 0) begin
                n_chk++; n_fail++;
                $display("FAIL R2: unexpected word actual %0d expected none", rd_data);
            end else begin
                check("R2 read order", int'(rd_data), int'(exp_q.pop_front()));
            end
        end
    end

    initial begin
        #(200000 * 20);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #2;
        // R1 reset state
        check("R1 empty", int'(empty), 1);
        check("R1 full", int'(full), 0);
        check("R1 half_full", int'(half_full), 0);
        check("R1 rd_valid", int'(rd_valid), 0);
        @(negedge clk);
        rst = 1'b0;

        // R5 read on empty ignored
        op(1'b0, '0, 1'b1, 1'b0, "R5");
        // R2 in-order reads
        for (int i = 0; i < 3; i++) op(1'b1, word_t'(9'h100 + i), 1'b0, 1'b0, "R2 write");
        for (int i = 0; i < 3; i++) op(1'b0, '0, 1'b1, 1'b0, "R2 read");
        // R7 rewind replays locations 0..2
        op(1'b0, '0, 1'b0, 1'b1, "R7 rewind");
        for (int i = 0; i < 3; i++) op(1'b0, '0, 1'b1, 1'b0, "R7 replay");
        // R9 bypass on empty
        op(1'b1, 9'h0A5, 1'b1, 1'b0, "R9 bypass");
        // R8 rewind ignored with read or write active
        op(1'b1, 9'h011, 1'b0, 1'b0, "R8 setup");
        op(1'b1, 9'h012, 1'b0, 1'b0, "R8 setup");
        op(1'b0, '0, 1'b1, 1'b1, "R8 rewind with read");
        op(1'b1, 9'h013, 1'b0, 1'b1, "R8 rewind with write");
        // R11 simultaneous in the middle
        op(1'b1, 9'h1C0, 1'b1, 1'b0, "R11 both");
        op(1'b1, 9'h1C1, 1'b1, 1'b0, "R11 both");
        // R3/R6 fill up, watch half_full rise
        while (m_cnt < DEPTH) op(1'b1, word_t'(9'h040 + m_cnt), 1'b0, 1'b0, "R3 R6 fill");
        // R4 write on full ignored
        op(1'b1, 9'h1FF, 1'b0, 1'b0, "R4 full write");
        // R10 read plus write on full
        op(1'b1, 9'h155, 1'b1, 1'b0, "R10 full swap");
        // R6 drain, half_full clears at exactly half
        while (m_cnt > 0) op(1'b0, '0, 1'b1, 1'b0, "R6 drain");
        op(1'b0, '0, 1'b1, 1'b0, "R5 empty again");
        // R1 reset mid-stream
        op(1'b1, 9'h077, 1'b0, 1'b0, "R1 pre-reset");
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk);
        #2;
        check("R1 empty after reset", int'(empty), 1);
        check("R1 rd_valid after reset", int'(rd_valid), 0);
        @(negedge clk);
        rst = 1'b0;
        m_wp = 0; m_rp = 0; m_cnt = 0;
        exp_q.delete();
        op(1'b0, '0, 1'b1, 1'b0, "R1 R5 read after reset");
        repeat (2) @(negedge clk);
        check("R2 all words seen", exp_q.size(), 0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule